// File: doc/BRIEF.md
# Sprite Horizontal Position Serializer

This block places up to four hardware sprites on a scan line. A color-clock counter counts the clocks of each line and returns to zero on every line-start strobe. Each sprite, called a player here, has a horizontal position register. When the counter reaches that position, the player's current 8-bit graphics byte is loaded into a shift register. The byte then leaves one bit per color clock, most significant bit first, so the sprite's left edge lands on the programmed clock.

Each player also has a color register that holds a hue in its upper nibble and a luminance in its lower nibble. When one or more players show a lit bit, the block raises a pixel-valid flag and drives the color of the lowest-numbered lit player. Placement is purely a count match. A position near either end of the count range therefore lets a sprite slide partly or fully off the visible window, which runs roughly from clock 44 to clock 220. A position of 228 or more never matches, so that sprite never appears.

Top module: `objsh_top`

## Requirements
- R1: After synchronous active-low reset, all positions and colors are 0, no shift is in progress, and `pix_valid` is 0 with `pix_color` equal to 0x00.
- R2: The color-clock count advances by one on each cycle with `cc_en` high and wraps from 227 to 0. A cycle with `line_start` high forces the count to 0, and this takes priority over `cc_en`.
- R3: In a cycle with `cc_en` high and the count equal to a player's position, that player's graphics byte (`gfx_bytes[8*i+7:8*i]`) is loaded. From the next cycle it is presented bit 7 first, one bit per further `cc_en` cycle, for exactly 8 color clocks.
- R4: In cycles with `cc_en` low, neither the count nor any shift advances, and no load takes place.
- R5: A match that occurs while a player's shift is still in progress restarts that player's shift with the graphics byte present at that moment.
- R6: A player whose position is 228 or more never produces a lit pixel.
- R7: When several players show a lit bit in the same clock, `pix_color` equals the color register of the lowest-numbered of them.
- R8: `pix_color` is 0x00 whenever `pix_valid` is 0. A color byte is passed through unchanged: hue in bits 7:4 and luminance in bits 3:0.
- R9: A write with `reg_wr_en` high stores `reg_wr_data` in the register selected by `reg_wr_addr`. Bit 2 of the address chooses between position (0) and color (1), and bits 1:0 give the player number. The new value takes effect from the next cycle.
- R10: `pix_valid` is high only in clocks where some player's currently presented bit is 1. Zero bits inside a graphics byte leave gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cc_en | input | 1 | Color-clock enable, one pulse per color clock |
| line_start | input | 1 | Start-of-line strobe; clears the color-clock count |
| gfx_bytes | input | 32 | Graphics bytes; player i occupies bits 8*i+7 down to 8*i |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Bit 2: 0 = position, 1 = color; bits 1:0 = player |
| reg_wr_data | input | 8 | Register write data |
| pix_valid | output | 1 | A player pixel is lit in this clock |
| pix_color | output | 8 | Hue and luminance of the winning player, 0 when not valid |

## Verification
A wrong internal count shows up as a sprite drawn at the wrong horizontal offset. The error appears within one line of 228 color clocks, and a missed wrap moves every later line. A shift counter that loses step makes a sprite too narrow, too wide or bit-reversed in the first clocks after its match, and a stuck shift leaves `pix_valid` set after the 8th clock. A priority or register-select fault shows as a wrong color in the first clock where two sprites overlap, or where the wrongly written register is used.

// File: rtl/objsh_pkg.sv
// Package: shared register-select encoding for the sprite serializer.
// Assumes the most significant write-address bit chooses the register bank.
package objsh_pkg;
    typedef enum logic {
        BANK_POS   = 1'b0,
        BANK_COLOR = 1'b1
    } reg_bank_e;
endpackage

// File: rtl/objsh_cc_counter.sv
// Module: color-clock counter for one scan line.
// Counts cc_en pulses modulo LINE_CLOCKS; line_start forces zero and wins over cc_en.
module objsh_cc_counter #(
    parameter int LINE_CLOCKS = 228,
    parameter int CNT_W       = $clog2(LINE_CLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cc_en,
    input  logic             line_start,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_CLOCKS - 1);

    // Advance, wrap or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (line_start) begin
            cnt <= '0;
        end else if (cc_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/objsh_lane.sv
// Module: one player's position compare and graphics shifter.
// Loads the graphics byte on a match and presents it MSB first for PIX_W color clocks.
// A fresh match during a shift reloads the byte and restarts the shift.
module objsh_lane #(
    parameter int PIX_W = 8,
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cc_en,
    input  logic [POS_W-1:0] cnt,
    input  logic [POS_W-1:0] pos,
    input  logic [PIX_W-1:0] gfx,
    output logic             lit
);
    localparam int LEFT_W = $clog2(PIX_W + 1);

    logic [PIX_W-1:0]  shreg;
    logic [LEFT_W-1:0] left;
    logic              hit;

    // Match strobe for this color clock.
    always_comb hit = cc_en && (cnt == pos);

    // Load on match, otherwise shift one bit per enabled color clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (hit) begin
            shreg <= gfx;
            left  <= LEFT_W'(PIX_W);
        end else if (cc_en && (left != '0)) begin
            shreg <= {shreg[PIX_W-2:0], 1'b0};
            left  <= left - 1'b1;
        end
    end

    // Presented bit is lit only while a shift is in progress.
    always_comb lit = (left != '0) && shreg[PIX_W-1];
endmodule

// File: rtl/objsh_prio_mux.sv
// Module: fixed-priority color select across players, index 0 highest.
// Drives zero color when no player is lit.
module objsh_prio_mux #(
    parameter int NUM_PLAYERS = 4,
    parameter int COLOR_W     = 8
) (
    input  logic [NUM_PLAYERS-1:0]         lit,
    input  logic [NUM_PLAYERS*COLOR_W-1:0] colors,
    output logic                           valid,
    output logic [COLOR_W-1:0]             color
);
    // Scan from lowest priority upward so the lowest index overrides.
    always_comb begin
        valid = |lit;
        color = '0;
        for (int i = NUM_PLAYERS - 1; i >= 0; i--) begin
            if (lit[i]) color = colors[i*COLOR_W +: COLOR_W];
        end
    end
endmodule

// File: rtl/objsh_top.sv
// Module: sprite horizontal position serializer top level.
// Holds per-player position and color registers, one shared color-clock counter,
// one shifter lane per player and a priority color mux. Assumes counter width <= POS_W.
module objsh_top #(
    parameter int NUM_PLAYERS = 4,
    parameter int PIX_W       = 8,
    parameter int POS_W       = 8,
    parameter int COLOR_W     = 8,
    parameter int LINE_CLOCKS = 228,
    parameter int SEL_W       = $clog2(NUM_PLAYERS),
    parameter int ADDR_W      = SEL_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cc_en,
    input  logic                         line_start,
    input  logic [NUM_PLAYERS*PIX_W-1:0] gfx_bytes,
    input  logic                         reg_wr_en,
    input  logic [ADDR_W-1:0]            reg_wr_addr,
    input  logic [POS_W-1:0]             reg_wr_data,
    output logic                         pix_valid,
    output logic [COLOR_W-1:0]           pix_color
);
    import objsh_pkg::*;

    localparam int CNT_W = $clog2(LINE_CLOCKS);

    logic [CNT_W-1:0]               cnt_q;
    logic [POS_W-1:0]               cnt_ext;
    logic [NUM_PLAYERS*POS_W-1:0]   pos_q;
    logic [NUM_PLAYERS*COLOR_W-1:0] col_q;
    logic [NUM_PLAYERS-1:0]         lit;
    reg_bank_e                      bank;
    logic [SEL_W-1:0]               who;

    // Decode the write address into bank and player.
    always_comb begin
        bank = reg_bank_e'(reg_wr_addr[ADDR_W-1]);
        who  = reg_wr_addr[SEL_W-1:0];
    end

    // Widen the count for comparison against positions.
    always_comb cnt_ext = POS_W'(cnt_q);

    objsh_cc_counter #(
        .LINE_CLOCKS(LINE_CLOCKS),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cc_en     (cc_en),
        .line_start(line_start),
        .cnt       (cnt_q)
    );

    generate
        for (genvar g = 0; g < NUM_PLAYERS; g++) begin : g_player
            // Position and color registers for this player.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pos_q[g*POS_W +: POS_W]     <= '0;
                    col_q[g*COLOR_W +: COLOR_W] <= '0;
                end else if (reg_wr_en && (who == SEL_W'(g))) begin
                    if (bank == BANK_POS)
                        pos_q[g*POS_W +: POS_W] <= reg_wr_data;
                    else
                        col_q[g*COLOR_W +: COLOR_W] <= COLOR_W'(reg_wr_data);
                end
            end

            objsh_lane #(
                .PIX_W(PIX_W),
                .POS_W(POS_W)
            ) u_lane (
                .clk  (clk),
                .rst_n(rst_n),
                .cc_en(cc_en),
                .cnt  (cnt_ext),
                .pos  (pos_q[g*POS_W +: POS_W]),
                .gfx  (gfx_bytes[g*PIX_W +: PIX_W]),
                .lit  (lit[g])
            );
        end
    endgenerate

    objsh_prio_mux #(
        .NUM_PLAYERS(NUM_PLAYERS),
        .COLOR_W    (COLOR_W)
    ) u_mux (
        .lit   (lit),
        .colors(col_q),
        .valid (pix_valid),
        .color (pix_color)
    );
endmodule

// File: rtl/objsh_chk.sv
// Module: assertion checker for objsh_top, attached through bind.
// Observes ports plus the internal color-clock count.
module objsh_chk #(
    parameter int LINE_CLOCKS = 228,
    parameter int CNT_W       = 8,
    parameter int COLOR_W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cc_en,
    input logic               line_start,
    input logic               reg_wr_en,
    input logic [CNT_W-1:0]   cnt_q,
    input logic               pix_valid,
    input logic [COLOR_W-1:0] pix_color
);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LINE_CLOCKS));

    // R2
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (cnt_q == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && !line_start && cnt_q != CNT_W'(LINE_CLOCKS - 1))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_en && !reg_wr_en) |=> ($stable(pix_valid) && $stable(pix_color)));

    // R8
    dark_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_color == '0));
endmodule

bind objsh_top objsh_chk #(
    .LINE_CLOCKS(LINE_CLOCKS),
    .CNT_W      ($clog2(LINE_CLOCKS)),
    .COLOR_W    (COLOR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cc_en     (cc_en),
    .line_start(line_start),
    .reg_wr_en (reg_wr_en),
    .cnt_q     (cnt_q),
    .pix_valid (pix_valid),
    .pix_color (pix_color)
);

// File: tb/objsh_top_test.sv
// Bench: behavioural reference model of the serializer, compared on every clock.
module objsh_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cc_en = 1'b0;
    logic        line_start = 1'b0;
    logic [31:0] gfx_bytes = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        pix_valid;
    logic [7:0]  pix_color;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit comparing = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference state
    int   m_cnt;
    int   m_pos [4];
    int   m_col [4];
    int   m_left[4];
    logic [7:0] m_sh[4];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    objsh_top uut (
        .clk(clk), .rst_n(rst_n), .cc_en(cc_en), .line_start(line_start),
        .gfx_bytes(gfx_bytes), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .pix_valid(pix_valid), .pix_color(pix_color)
    );

    // Reference model update, using the inputs present at this edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0;
            for (int i = 0; i < 4; i++) begin
                m_pos[i] = 0; m_col[i] = 0; m_left[i] = 0; m_sh[i] = 8'h00;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (cc_en && m_cnt == m_pos[i]) begin
                    m_sh[i] = gfx_bytes[8*i +: 8];
                    m_left[i] = 8;
                end else if (cc_en && m_left[i] > 0) begin
                    m_sh[i] = m_sh[i] << 1;
                    m_left[i] = m_left[i] - 1;
                end
            end
            if (line_start) m_cnt = 0;
            else if (cc_en) m_cnt = (m_cnt + 1) % 228;
            if (reg_wr_en) begin
                if (reg_wr_addr[2]) m_col[reg_wr_addr[1:0]] = reg_wr_data;
                else m_pos[reg_wr_addr[1:0]] = reg_wr_data;
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (comparing && !done) begin
            logic       ev;
            logic [7:0] ec;
            ev = 1'b0; ec = 8'h00;
            for (int i = 3; i >= 0; i--) begin
                if (m_left[i] > 0 && m_sh[i][7]) begin
                    ev = 1'b1; ec = 8'(m_col[i]);
                end
            end
            checks++;
            if (pix_valid !== ev || pix_color !== ec) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%b color=%02h expected valid=%b color=%02h",
                         cur_req, cyc, pix_valid, pix_color, ev, ec);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic strobe_line();
        @(negedge clk);
        line_start = 1'b1; cc_en = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // Run n cycles; mode 0: cc_en always high, mode 1: pseudo-random cc_en.
    task automatic run(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cc_en = (mode == 0) ? 1'b1 : lfsr[0];
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the outputs
        checks++;
        if (pix_valid !== 1'b0 || pix_color !== 8'h00) begin
            fails++;
            $display("FAIL R1: valid=%b color=%02h expected valid=0 color=00", pix_valid, pix_color);
        end
        comparing = 1'b1;

        // R3 / R8: single sprite, pattern and color pass-through
        cur_req = "R3";
        gfx_bytes = 32'h000000A5;
        wr(3'b000, 8'd50);
        wr(3'b100, 8'h3A);
        strobe_line();
        run(300, 0);

        // R10: sparse pattern leaves gaps
        cur_req = "R10";
        gfx_bytes = 32'h00000081;
        strobe_line();
        run(240, 0);

        // R4: irregular color-clock enable
        cur_req = "R4";
        gfx_bytes = 32'h000000C3;
        strobe_line();
        run(700, 1);

        // R5: re-match mid-shift via line restart
        cur_req = "R5";
        cc_en = 1'b1;
        wr(3'b000, 8'd2);
        gfx_bytes = 32'h000000F0;
        strobe_line();
        run(4, 0);
        gfx_bytes = 32'h000000AA;
        strobe_line();
        run(20, 0);

        // R9 / R7: all four players overlap with distinct colors
        cur_req = "R9";
        wr(3'b000, 8'd120);
        wr(3'b001, 8'd122);
        wr(3'b010, 8'd124);
        wr(3'b011, 8'd126);
        wr(3'b101, 8'h5C);
        wr(3'b110, 8'h94);
        wr(3'b111, 8'hE2);
        cur_req = "R7";
        gfx_bytes = 32'h81_FF_3C_99;
        strobe_line();
        run(500, 0);
        run(400, 1);

        // R6: positions beyond the line never show
        cur_req = "R6";
        gfx_bytes = 32'hFFFF_FFFF;
        wr(3'b000, 8'd228);
        wr(3'b001, 8'd240);
        wr(3'b010, 8'd255);
        wr(3'b011, 8'd230);
        strobe_line();
        run(700, 0);

        // R2: free-running wrap without line strobes, sprite at clock 0 and at 227
        cur_req = "R2";
        wr(3'b000, 8'd0);
        wr(3'b011, 8'd227);
        gfx_bytes = 32'h0F_00_00_E1;
        run(1000, 0);
        strobe_line();
        run(100, 0);
        strobe_line();
        run(400, 1);

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule